// File: doc/BRIEF.md
# Input-Stream DMA Control Register

This block is the control register for one input-stream DMA channel, together with its sticky event flags and interrupt gating. A small register bus writes and reads two bytes: a control byte (address 0) that holds the run request, the stream-reset request and three interrupt enables, and a flag byte (address 1) that holds the event flags. The block sends an enable and a stream-reset request to the DMA engine. It takes back two level handshakes: one says the engine has really stopped, the other says the stream hardware is in reset.

The run and reset bits of the control byte read back the state the engine has acknowledged, not the value last written. Software therefore reads RUN as 1 until the engine has drained. It reads the reset bit as 1 only while the stream hardware is really held in reset. Each interrupt enable gates only the interrupt line; the matching flag latches whether or not it is enabled. When the FIFO overflows, incoming samples are dropped either way. The engine does the dropping and sees the same error pulse.

Top module: `stream_ctl`

## Requirements
- R1: Control bits 7:5 always read 0, and writing ones to them changes no read-back or output.
- R2: Control bits 2, 3 and 4 are read/write enables for the completion, FIFO-error and descriptor-error interrupts, and all three read 0 after reset.
- R3: `dma_en` is high exactly when the last accepted RUN write (control bit 1) was 1 and `stream_sync` is 0.
- R4: Control bit 1 reads 1 while the written RUN is 1 or `eng_stopped` is 0, so after RUN is cleared it keeps reading 1 until the engine reports stopped.
- R5: Writing 1 to control bit 0 while RUN reads 0 raises `srst_req` on the next cycle, and bit 0 reads 1 only once `rst_ack` has risen.
- R6: Writing 0 to control bit 0 during a stream reset drops `srst_req` on the next cycle, and bit 0 keeps reading 1 until `rst_ack` falls.
- R7: Accepting a stream reset clears RUN, the three enables and all flags. While `srst_req` is high, writes change only bit 0 and event pulses set no flag.
- R8: Flag bits 2, 3 and 4 at address 1 latch the completion, FIFO-error and descriptor-error pulses whatever the enables are, and an event in the same cycle as a clear of its flag wins. All other flag bits read 0.
- R9: `irq` is high exactly when some flag is set and its enable, at the same bit position of the control byte, is set.
- R10: A write with bit 0 set while control bit 1 reads 1 starts no reset, and the write's other fields are still applied.
- R11: Writing 1 to a flag bit clears it on the next cycle, and writing 0 to a flag bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | 0 selects the control byte, 1 the flag byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed byte (combinational) |
| stream_sync | input | 1 | Holds the engine off while high |
| dma_en | output | 1 | Run enable to the DMA engine |
| srst_req | output | 1 | Stream reset request; also clears the stream FIFO |
| eng_stopped | input | 1 | High when the engine has actually stopped |
| rst_ack | input | 1 | High while the stream hardware is held in reset |
| evt_ioc | input | 1 | Pulse: a buffer flagged for interrupt completed |
| evt_fifo_err | input | 1 | Pulse: FIFO overrun |
| evt_desc_err | input | 1 | Pulse: descriptor error |
| irq | output | 1 | Interrupt line |

## Verification
The embedded assertions check the following on every cycle. A reset request written while RUN still reads 1 is refused. The enables and RUN stay frozen while a reset is held. Every unmasked event pulse lands in its flag, and a clear without a competing event empties the flag. The interrupt never rises without a latched flag. Only the bench's scenarios can show the acknowledged read-back during the stop and reset transitions under different handshake delays, and the event-wins-over-clear collision. The same holds for flags that stay set with their interrupt masked, and for the exit from reset with the reset bit still reading 1.

// File: rtl/stream_ctl_pkg.sv
// Package: shared field positions and sizes for the stream control register.
// Assumes an 8-bit register byte with the event enables and flags at the
// same bit positions, so one slice selects both.
package stream_ctl_pkg;
    localparam int REG_W    = 8;  // register byte width
    localparam int BIT_SRST = 0;  // stream reset request / acknowledge
    localparam int BIT_RUN  = 1;  // run request / engine activity
    localparam int EVT_LSB  = 2;  // first enable / flag bit
    localparam int N_EVT    = 3;  // completion, FIFO error, descriptor error
    localparam logic ADDR_STS = 1'b1; // bus address of the flag byte
endpackage

// File: rtl/sctl_ctrl_regs.sv
// Module: control fields of the stream (RUN, enables, reset request).
// Assumes writes arrive as one-cycle strobes already decoded for address 0.
// A reset request is only accepted while the acknowledged RUN reads 0.
module sctl_ctrl_regs #(
    parameter int N_EVT = stream_ctl_pkg::N_EVT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_run,
    input  logic             wr_srst,
    input  logic [N_EVT-1:0] wr_en,
    input  logic             run_busy,
    output logic             run_q,
    output logic             srst_q,
    output logic [N_EVT-1:0] evt_en,
    output logic             srst_accept
);
    logic run_seen;

    // Purpose: acknowledged RUN as software sees it, used to refuse a reset.
    always_comb begin
        run_seen    = run_q | run_busy;
        srst_accept = wr_ctl & wr_srst & ~run_seen & ~srst_q;
    end

    // Purpose: register the control fields with reset-hold priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            srst_q <= 1'b0;
            evt_en <= '0;
        end else if (srst_q) begin
            if (wr_ctl) begin
                srst_q <= wr_srst;
            end
        end else if (srst_accept) begin
            srst_q <= 1'b1;
            run_q  <= 1'b0;
            evt_en <= '0;
        end else if (wr_ctl) begin
            run_q  <= wr_run;
            evt_en <= wr_en;
        end
    end

    AST_SRST_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wr_srst && (run_q || run_busy) && !srst_q) |=> !srst_q); // R10

    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && $past(srst_q)) |-> ($stable(evt_en) && !run_q)); // R7
endmodule

// File: rtl/sctl_status.sv
// Module: sticky event flags, one per event source, write-one-to-clear.
// Assumes event inputs are single-cycle pulses. An event in the same cycle
// as its clear wins; hold_clear empties every flag and blocks events.
module sctl_status #(
    parameter int N_EVT = stream_ctl_pkg::N_EVT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] clr,
    input  logic             hold_clear,
    output logic [N_EVT-1:0] sts_q
);
    for (genvar i = 0; i < N_EVT; i++) begin : g_flag
        // Purpose: set on event, clear on write-one, empty during stream reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[i] <= 1'b0;
            end else if (hold_clear) begin
                sts_q[i] <= 1'b0;
            end else if (evt[i]) begin
                sts_q[i] <= 1'b1;
            end else if (clr[i]) begin
                sts_q[i] <= 1'b0;
            end
        end

        AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && !hold_clear) |=> sts_q[i]); // R8

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt[i]) |=> !sts_q[i]); // R11
    end
endmodule

// File: rtl/sctl_irq.sv
// Module: interrupt gating; each enable masks only the line, not the flag.
// Assumes flags and enables share bit order.
module sctl_irq #(
    parameter int N_EVT = stream_ctl_pkg::N_EVT
) (
    input  logic [N_EVT-1:0] sts,
    input  logic [N_EVT-1:0] en,
    output logic             irq
);
    // Purpose: OR of every flag masked by its enable.
    always_comb begin
        irq = |(sts & en);
    end
endmodule

// File: rtl/stream_ctl.sv
// Module: top of the input-stream control register. Decodes the two-byte
// register bus, builds the acknowledged read-back and drives the engine.
// Assumes eng_stopped and rst_ack are synchronous levels from the engine.
module stream_ctl
    import stream_ctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         stream_sync,
    output logic         dma_en,
    output logic         srst_req,
    input  logic         eng_stopped,
    input  logic         rst_ack,
    input  logic         evt_ioc,
    input  logic         evt_fifo_err,
    input  logic         evt_desc_err,
    output logic         irq
);
    localparam int HI_LSB = EVT_LSB + N_EVT;

    logic             wr_ctl;
    logic [N_EVT-1:0] clr_mask;
    logic [N_EVT-1:0] evt_vec;
    logic             run_q;
    logic             srst_q;
    logic [N_EVT-1:0] evt_en;
    logic [N_EVT-1:0] sts_q;
    logic             srst_accept;
    logic [W-1:0]     ctl_rd;
    logic [W-1:0]     sts_rd;
    logic             unused_hi;

    // Purpose: decode the bus write and pack the event pulses.
    always_comb begin
        wr_ctl    = bus_wr & (bus_addr != ADDR_STS);
        clr_mask  = (bus_wr && bus_addr == ADDR_STS) ? bus_wdata[EVT_LSB +: N_EVT] : '0;
        evt_vec   = {evt_desc_err, evt_fifo_err, evt_ioc};
        unused_hi = ^bus_wdata[W-1:HI_LSB];
    end

    sctl_ctrl_regs #(.N_EVT(N_EVT)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctl      (wr_ctl),
        .wr_run      (bus_wdata[BIT_RUN]),
        .wr_srst     (bus_wdata[BIT_SRST]),
        .wr_en       (bus_wdata[EVT_LSB +: N_EVT]),
        .run_busy    (~eng_stopped),
        .run_q       (run_q),
        .srst_q      (srst_q),
        .evt_en      (evt_en),
        .srst_accept (srst_accept)
    );

    sctl_status #(.N_EVT(N_EVT)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_vec),
        .clr        (clr_mask),
        .hold_clear (srst_q | srst_accept),
        .sts_q      (sts_q)
    );

    sctl_irq #(.N_EVT(N_EVT)) u_irq (
        .sts (sts_q),
        .en  (evt_en),
        .irq (irq)
    );

    // Purpose: acknowledged read-back of both bytes and the engine outputs.
    always_comb begin
        ctl_rd                       = '0;
        ctl_rd[BIT_SRST]             = rst_ack;
        ctl_rd[BIT_RUN]              = run_q | ~eng_stopped;
        ctl_rd[EVT_LSB +: N_EVT]     = evt_en;
        sts_rd                       = '0;
        sts_rd[EVT_LSB +: N_EVT]     = sts_q;
        bus_rdata = (bus_addr == ADDR_STS) ? sts_rd : ctl_rd;
        dma_en    = run_q & ~stream_sync;
        srst_req  = srst_q;
    end

    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|sts_q)); // R9
endmodule

// File: tb/stream_ctl_test.sv
module stream_ctl_test;
    localparam time CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stream_sync = 1'b0;
    logic       dma_en, srst_req, irq;
    logic       eng_stopped = 1'b1;
    logic       rst_ack = 1'b0;
    logic       e_ioc = 1'b0, e_fifo = 1'b0, e_desc = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int stop_dly = 3;
    int rst_dly = 4;
    int stop_cnt = 0;
    int rst_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_ctl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stream_sync(stream_sync),
        .dma_en(dma_en), .srst_req(srst_req), .eng_stopped(eng_stopped),
        .rst_ack(rst_ack), .evt_ioc(e_ioc), .evt_fifo_err(e_fifo),
        .evt_desc_err(e_desc), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Engine environment: programmable stop and reset handshake delays.
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_stopped <= 1'b1; rst_ack <= 1'b0; stop_cnt <= 0; rst_cnt <= 0;
        end else begin
            if (dma_en) begin
                eng_stopped <= 1'b0; stop_cnt <= 0;
            end else if (!eng_stopped) begin
                if (stop_cnt >= stop_dly - 1) begin
                    eng_stopped <= 1'b1; stop_cnt <= 0;
                end else stop_cnt <= stop_cnt + 1;
            end
            if (srst_req !== rst_ack) begin
                if (rst_cnt >= rst_dly - 1) begin
                    rst_ack <= srst_req; rst_cnt <= 0;
                end else rst_cnt <= rst_cnt + 1;
            end else rst_cnt <= 0;
        end
    end

    // Behavioural reference model, advanced on every rising edge.
    bit       m_run = 0, m_srst = 0;
    bit [2:0] m_en = 0, m_sts = 0;
    always @(posedge clk) begin
        bit       busy_rd;
        bit [2:0] ev;
        bit       w_ctl, w_sts;
        ev      = {e_desc, e_fifo, e_ioc};
        busy_rd = m_run || !eng_stopped;
        w_ctl   = bus_wr && !bus_addr;
        w_sts   = bus_wr && bus_addr;
        if (!rst_n) begin
            m_run = 0; m_srst = 0; m_en = 0; m_sts = 0;
        end else if (m_srst) begin
            if (w_ctl) m_srst = bus_wdata[0];
            m_sts = 0;
        end else if (w_ctl && bus_wdata[0] && !busy_rd) begin
            m_srst = 1; m_run = 0; m_en = 0; m_sts = 0;
        end else begin
            if (w_ctl) begin
                m_run = bus_wdata[1];
                m_en  = bus_wdata[4:2];
            end
            for (int i = 0; i < 3; i++) begin
                if (ev[i]) m_sts[i] = 1;
                else if (w_sts && bus_wdata[2+i]) m_sts[i] = 0;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_addr) begin
                chk({5'b0, bus_rdata[7:5]}, 8'h00, "R1 reserved bits");
                chk({5'b0, bus_rdata[4:2]}, {5'b0, m_en}, "R2 enables");
                chk({7'b0, bus_rdata[1]}, {7'b0, m_run || !eng_stopped}, "R4 run readback");
                chk({7'b0, bus_rdata[0]}, {7'b0, rst_ack}, "R5 R6 reset readback");
            end else begin
                chk(bus_rdata, {3'b0, m_sts, 2'b00}, "R8 flags");
            end
            chk({7'b0, dma_en}, {7'b0, m_run && !stream_sync}, "R3 dma_en");
            chk({7'b0, srst_req}, {7'b0, m_srst}, "R5 R6 srst_req");
            chk({7'b0, irq}, {7'b0, |(m_sts & m_en)}, "R9 irq");
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(posedge clk); #1;
        {e_desc, e_fifo, e_ioc} = ev;
        @(posedge clk); #1;
        {e_desc, e_fifo, e_ioc} = 3'b000;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_rd(input logic a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        chk(bus_rdata, exp, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all requirements): got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // Reset state
        expect_rd(0, 8'h00, "R2 reset control");
        expect_rd(1, 8'h00, "R8 reset flags");
        chk({7'b0, irq}, 8'h00, "R9 reset irq");
        // Reserved bits ignored, enables stick
        wr(0, 8'hFC);
        expect_rd(0, 8'h1C, "R1 R2 write FC");
        // Completion event, enabled
        pulse(3'b001);
        expect_rd(1, 8'h04, "R8 completion flag");
        chk({7'b0, irq}, 8'h01, "R9 irq enabled");
        wr(1, 8'h04);
        expect_rd(1, 8'h00, "R11 clear completion");
        // Masked events still latch
        wr(0, 8'h00);
        pulse(3'b110);
        expect_rd(1, 8'h18, "R8 masked flags latch");
        chk({7'b0, irq}, 8'h00, "R9 masked irq");
        wr(1, 8'h00);
        expect_rd(1, 8'h18, "R11 write zero keeps");
        wr(0, 8'h10);
        chk({7'b0, irq}, 8'h01, "R9 desc enable");
        wr(1, 8'h18);
        expect_rd(1, 8'h00, "R11 clear both");
        // Event collides with clear
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h08; e_fifo = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; e_fifo = 1'b0;
        expect_rd(1, 8'h08, "R8 event beats clear");
        wr(1, 8'h08);
        // Run and stream sync
        wr(0, 8'h02);
        chk({7'b0, dma_en}, 8'h01, "R3 run on");
        @(posedge clk); #1; stream_sync = 1'b1;
        @(negedge clk);
        chk({7'b0, dma_en}, 8'h00, "R3 sync holds off");
        @(posedge clk); #1; stream_sync = 1'b0;
        idle(2);
        // Clear RUN with reset request while engine drains
        wr(0, 8'h05);
        expect_rd(0, 8'h06, "R4 R10 run still reads 1");
        chk({7'b0, srst_req}, 8'h00, "R10 reset refused");
        idle(stop_dly + 2);
        expect_rd(0, 8'h04, "R4 engine stopped");
        // Enter stream reset with a flag set
        pulse(3'b001);
        wr(0, 8'h1D);
        chk({7'b0, srst_req}, 8'h01, "R5 reset request");
        expect_rd(0, 8'h00, "R5 R7 before ack");
        expect_rd(1, 8'h00, "R7 flags cleared");
        idle(rst_dly + 2);
        expect_rd(0, 8'h01, "R5 ack reads 1");
        wr(0, 8'h1F);
        expect_rd(0, 8'h01, "R7 fields frozen");
        chk({7'b0, dma_en}, 8'h00, "R7 no run in reset");
        pulse(3'b111);
        expect_rd(1, 8'h00, "R7 events ignored");
        wr(0, 8'h00);
        chk({7'b0, srst_req}, 8'h00, "R6 reset released");
        expect_rd(0, 8'h01, "R6 reads 1 until ready");
        idle(rst_dly + 2);
        expect_rd(0, 8'h00, "R6 ready");
        // Second pass with other handshake delays
        stop_dly = 6; rst_dly = 2;
        wr(0, 8'h0E);
        idle(3);
        wr(0, 8'h0C);
        expect_rd(0, 8'h0E, "R4 long drain");
        idle(stop_dly + 2);
        wr(0, 8'h01);
        idle(rst_dly + 2);
        expect_rd(0, 8'h01, "R5 short ack");
        wr(0, 8'h00);
        idle(rst_dly + 2);
        expect_rd(0, 8'h00, "R6 short exit");
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule